// File: doc/BRIEF.md
# Single-Write Burst Terminator

This block runs the write data phase that follows each write command to a memory whose burst length is fixed at eight beats. A requester raises `wr_go` together with the memory type (`cfg_ddr`) and the access kind (`wr_single`). The block takes them when it is `ready`. It then marks the write command cycle, the beats on which write data must be driven, the data-mask value for each byte lane, and the strobe enable.

For a burst access all eight beats carry data. For a single access only the first beat is valid. The seven beats that follow must not change memory. On single-rate memory a burst-stop command ends the write in the cycle after the valid beat. On double-rate memory burst stop cannot end a write, so the block keeps the strobe running through all eight beats and raises the mask on every beat after the first. Double-rate memory also places its first data beat one cycle after the write command. Single-rate memory places it in the same cycle as the command.

Top module: `wr_burst_term`

## Requirements
- R1: After reset the block shows `ready`=1, `cmd_wr`=0, `cmd_bst`=0, `data_valid`=0, `dqs_en`=0, and every `dm` bit is 1.
- R2: When `wr_go` is high at a clock edge while `ready` is high, `cmd_wr` is high for exactly the next cycle and `ready` stays low until the data phase ends. A `wr_go` seen while `ready` is low is ignored.
- R3: With `cfg_ddr`=0 (single-rate memory) the first data beat (`data_valid`=1, `beat_idx`=0) falls in the same cycle as `cmd_wr`.
- R4: With `cfg_ddr`=1 (double-rate memory) the first data beat falls in the cycle after `cmd_wr`, and `dm` is all ones in the `cmd_wr` cycle.
- R5: A burst access (`wr_single`=0) gives eight consecutive beats with `data_valid`=1, `beat_idx` counting 0 to 7 and `dm` all zeros. `ready` returns in the cycle after the eighth beat.
- R6: A single access to single-rate memory gives one valid beat. The next cycle carries `cmd_bst`=1 with `data_valid`=0 and `dm` all ones, and `ready` returns in the cycle after that.
- R7: A single access to double-rate memory keeps `dqs_en` high for eight consecutive beat cycles. `data_valid` is high and `dm` is all zeros only on the first of them, `dm` is all ones on the other seven, and `cmd_bst` stays 0.
- R8: While `ready` is high, `dm` is all ones and `dqs_en` is low. `dqs_en` is never high for single-rate memory.
- R9: `cfg_ddr` and `wr_single` are captured when a command is taken. Changes to them during the data phase do not alter that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_ddr | input | 1 | Memory type: 1 = double data rate, 0 = single data rate |
| wr_single | input | 1 | 1 = single access, 0 = eight-beat burst |
| wr_go | input | 1 | Write request, taken when `ready` is high |
| ready | output | 1 | Block is idle and takes a new request |
| cmd_wr | output | 1 | Write command cycle |
| cmd_bst | output | 1 | Burst-stop command request |
| data_valid | output | 1 | Current beat carries real write data |
| beat_idx | output | 3 | Index of the current beat within the burst |
| dm | output | LANES (2) | Per-lane data mask, 1 = beat ignored by memory |
| dqs_en | output | 1 | Strobe enable for double-rate beats |

## Verification
The bench builds the block with its default of two mask lanes and an eight-beat burst. This keeps the full data phase of every configuration short enough to compare cycle by cycle. It sweeps every combination of memory type and access kind. It holds `wr_go` high and flips both configuration inputs during each phase, which exercises the ignored-request and latched-configuration paths. Expected command, beat, mask and strobe values come from the cycle offset after acceptance, worked out arithmetically from the latency and the window length.

// File: rtl/wbt_pkg.sv
package wbt_pkg;
    localparam int BURST_LEN = 8;
    localparam int CNT_W     = $clog2(BURST_LEN);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LAT  = 2'd1,
        PH_BEAT = 2'd2,
        PH_STOP = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic               ddr;
        logic               single;
    } wbt_state_t;
endpackage

// File: rtl/wbt_beat_ctr.sv
module wbt_beat_ctr
    import wbt_pkg::*;
(
    input  logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_inc,
    output logic             cnt_last
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BURST_LEN - 1);

    always_comb begin
        cnt_inc  = cnt_q + CNT_W'(1);
        cnt_last = (cnt_q == LAST);
    end
endmodule

// File: rtl/wbt_mask_fan.sv
module wbt_mask_fan #(
    parameter int LANES = 2
) (
    input  logic             mask_bit,
    output logic [LANES-1:0] dm
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dm[g] = mask_bit;
    end
endmodule

// File: rtl/wr_burst_term.sv
module wr_burst_term
    import wbt_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_ddr,
    input  logic                  wr_single,
    input  logic                  wr_go,
    output logic                  ready,
    output logic                  cmd_wr,
    output logic                  cmd_bst,
    output logic                  data_valid,
    output logic [CNT_W-1:0]      beat_idx,
    output logic [LANES-1:0]      dm,
    output logic                  dqs_en
);
    wbt_state_t       st_d, st_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             cnt_last;
    logic             mask_bit;

    wbt_beat_ctr u_ctr (
        .cnt_q   (st_q.cnt),
        .cnt_inc (cnt_inc),
        .cnt_last(cnt_last)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (wr_go) begin
                    st_d.ddr    = cfg_ddr;
                    st_d.single = wr_single;
                    st_d.cnt    = '0;
                    st_d.phase  = cfg_ddr ? PH_LAT : PH_BEAT;
                end
            end
            PH_LAT: begin
                st_d.phase = PH_BEAT;
            end
            PH_BEAT: begin
                if (!st_q.ddr && st_q.single) begin
                    st_d.phase = PH_STOP;
                end else if (cnt_last) begin
                    st_d.phase = PH_IDLE;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = cnt_inc;
                end
            end
            PH_STOP: begin
                st_d.phase = PH_IDLE;
                st_d.cnt   = '0;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, ddr: 1'b0, single: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // Output decode from registered state.
    always_comb begin
        ready      = (st_q.phase == PH_IDLE);
        cmd_wr     = (st_q.phase == PH_LAT) ||
                     (st_q.phase == PH_BEAT && !st_q.ddr && st_q.cnt == '0);
        cmd_bst    = (st_q.phase == PH_STOP);
        data_valid = (st_q.phase == PH_BEAT) && (!st_q.single || st_q.cnt == '0);
        dqs_en     = (st_q.phase == PH_BEAT) && st_q.ddr;
        beat_idx   = st_q.cnt;
        mask_bit   = !data_valid;
    end

    wbt_mask_fan #(.LANES(LANES)) u_fan (
        .mask_bit(mask_bit),
        .dm      (dm)
    );
endmodule

// File: rtl/wr_burst_term_chk.sv
module wr_burst_term_chk #(
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ready,
    input logic             cmd_wr,
    input logic             cmd_bst,
    input logic             data_valid,
    input logic [LANES-1:0] dm,
    input logic             dqs_en
);
    p_cmd_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> !cmd_wr);

    p_cmd_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |-> !ready);

    p_valid_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> (dm == '0));

    p_bst_after_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_bst |-> ($past(data_valid) && !data_valid && (&dm)));

    p_bst_then_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_bst |=> ready);

    p_no_bst_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dqs_en |-> !cmd_bst);

    p_idle_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> ((&dm) && !dqs_en && !data_valid));
endmodule

bind wr_burst_term wr_burst_term_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready     (ready),
    .cmd_wr    (cmd_wr),
    .cmd_bst   (cmd_bst),
    .data_valid(data_valid),
    .dm        (dm),
    .dqs_en    (dqs_en)
);

// File: tb/wr_burst_term_test.sv
module wr_burst_term_test;
    localparam int LANES = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_ddr = 1'b0;
    logic             wr_single = 1'b0;
    logic             wr_go = 1'b0;
    logic             ready, cmd_wr, cmd_bst, data_valid, dqs_en;
    logic [2:0]       beat_idx;
    logic [LANES-1:0] dm;

    int total = 0;
    int bad   = 0;

    always #10ns clk = ~clk;

    wr_burst_term #(.LANES(LANES)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_ddr(cfg_ddr), .wr_single(wr_single),
        .wr_go(wr_go), .ready(ready), .cmd_wr(cmd_wr), .cmd_bst(cmd_bst),
        .data_valid(data_valid), .beat_idx(beat_idx), .dm(dm), .dqs_en(dqs_en)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic run_case(input bit ddr, input bit single);
        string tag;
        bit    seen_first;
        tag = (!single) ? "R5" : (ddr ? "R7" : "R6");
        seen_first = 1'b0;
        @(negedge clk);
        cfg_ddr   = ddr;
        wr_single = single;
        wr_go     = 1'b1;
        @(posedge clk);
        for (int t = 1; t <= 12; t++) begin
            int  b;
            bit  e_valid, e_bst, e_ready, e_dqs, e_cmd;
            @(negedge clk);
            e_cmd = (t == 1);
            if (!ddr && single) begin
                e_valid = (t == 1);
                e_bst   = (t == 2);
                e_ready = (t >= 3);
                e_dqs   = 1'b0;
                b       = 0;
            end else begin
                b       = t - 1 - int'(ddr);
                e_valid = (b >= 0 && b < 8) && (!single || b == 0);
                e_bst   = 1'b0;
                e_ready = (t > 8 + int'(ddr));
                e_dqs   = ddr && (b >= 0 && b < 8);
            end
            chk("R2", "cmd_wr", cmd_wr, e_cmd);
            chk("R2", "ready", ready, e_ready);
            chk(tag, "data_valid", data_valid, e_valid);
            chk(tag, "cmd_bst", cmd_bst, e_bst);
            chk(e_ready ? "R8" : tag, "dqs_en", dqs_en, e_dqs);
            chk(e_ready ? "R8" : tag, "dm", dm, e_valid ? 0 : (1 << LANES) - 1);
            if (e_valid) chk(tag, "beat_idx", beat_idx, b);
            if (data_valid && !seen_first) begin
                seen_first = 1'b1;
                chk(ddr ? "R4" : "R3", "first beat offset", t, ddr ? 2 : 1);
            end
            // R9: flip configuration mid-phase; R2: wr_go held while busy
            if (t == 1) begin
                cfg_ddr   = ~ddr;
                wr_single = ~single;
            end
            if (e_ready) wr_go = 1'b0;
        end
        chk(tag, "first beat seen", seen_first, 1);
    endtask

    initial begin
        #50ns;
        @(negedge clk);
        chk("R1", "ready", ready, 1);
        chk("R1", "cmd_wr", cmd_wr, 0);
        chk("R1", "cmd_bst", cmd_bst, 0);
        chk("R1", "data_valid", data_valid, 0);
        chk("R1", "dqs_en", dqs_en, 0);
        chk("R1", "dm", dm, (1 << LANES) - 1);
        rst_n = 1'b1;
        for (int rep = 0; rep < 2; rep++) begin
            for (int k = 0; k < 4; k++) begin
                run_case(k[1], k[0]);
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2ms;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule